// File: doc/BRIEF.md
# Serial-Bus Master Transfer Sequencer

This block is the master-side control state machine of a two-wire serial-bus controller. Software programs a byte count and a slave address, then writes the control register with the start bit set. The block orders an addressed start from a byte-level bus engine in the requested direction. It then moves bytes between a small packing buffer and that engine, counts the programmed length down, and issues a stop when asked. Ready and error events go to the status unit.

There are two modes. In counted mode the live counter limits the transfer. When the count runs out, a pending stop ends the transfer. With no stop pending, the bus is held, an access-ready event is raised and the master bit drops. In repeat mode the count is ignored: transmit drains whatever the host has buffered, receive keeps the buffer topped up, and a pending stop ends the transfer at once. The engine is abstract. Each command (start, send, receive, stop) is held until the engine answers with a done pulse and, for start and send, an acknowledge flag. Bit-level line timing, slave operation and 10-bit addressing belong elsewhere.

Top module: `xfer_seq`

## Requirements
- R1: After reset the control register reads 0, the live count reads 0, the bus is idle, no engine command is pending, and the transmit-ready and receive-ready levels are low.
- R2: A control write keeps only the bits under mask 0xCF87. The bit positions are: start 0, stop 1, repeat 2, direction 9 (1 = transmit), master 10, byte-order 14, enable 15. The start bit always reads back 0. A start is only accepted when the written value has enable, master and start set, and no engine command is outstanding. It issues a START command carrying the slave address, with the read flag equal to the inverse of the direction bit.
- R3: If the engine does not acknowledge the START, a NACK event pulses, the stop bit clears, the bus returns to idle, and no further command is issued.
- R4: An accepted start empties the packing buffer. An acknowledged START loads the live count from the programmed count.
- R5: In counted transmit, one SEND is issued per buffered byte, in push order, while the live count is non-zero. Each completed SEND decrements the count. With the buffer empty, the block waits.
- R6: Transmit-ready is high while a transmit transfer can still take data, that is while the count is non-zero (counted) or no stop is pending (repeat). It is low after the count is exhausted, after a NACK, and while idle.
- R7: In counted receive, RECV commands are issued while the count is non-zero and the buffer holds fewer than DEPTH (4) bytes. Each completed RECV decrements the count. Received bytes pop out in arrival order. Receive-ready equals "receive direction and buffer not empty".
- R8: When the count is zero and stop is set, a STOP command is issued and the stop bit clears. When the STOP completes, the live count reloads from the programmed count and the bus goes idle.
- R9: When the count is zero and stop is clear, an access-ready event pulses, the master bit clears and the bus stays held. No command follows until a control write with start (new START) or with enable and stop (STOP).
- R10: In repeat mode the live count never changes, transmit sends every buffered byte, receive refills the buffer up to DEPTH bytes, and a pending stop issues STOP at once.
- R11: A SEND that is not acknowledged pulses NACK, clears the stop bit, and leaves the bus held with no further SEND.
- R12: At most one engine command is outstanding. Its request, opcode and operands stay stable until the done pulse. The opcode encoding is START 0, SEND 1, RECV 2, STOP 3.
- R13: With OLD_REV set, a control write with the enable bit clear resets the whole block: control register, programmed and live counts, buffer and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_q | output | 16 | Control register contents |
| cnt_we | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CW | Programmed count value |
| cnt_live | output | CW | Live remaining count |
| sa | input | 10 | Slave address |
| tx_we | input | 1 | Push one transmit byte (ignored when full or receiving) |
| tx_byte | input | DW | Transmit byte |
| rx_re | input | 1 | Pop one received byte |
| rx_byte | output | DW | Oldest byte in the buffer |
| eng_req | output | 1 | Engine command pending |
| eng_op | output | 2 | Engine opcode |
| eng_addr | output | 10 | Slave address for START |
| eng_rd | output | 1 | START direction, 1 = read |
| eng_wbyte | output | DW | Byte for SEND |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 1 | Acknowledge seen for START/SEND |
| eng_rbyte | input | DW | Byte returned by RECV |
| bus_busy | output | 1 | Bus owned by this master |
| xrdy | output | 1 | Transmit-ready level |
| rrdy | output | 1 | Receive-ready level |
| ardy_set | output | 1 | Access-ready event pulse |
| nack_set | output | 1 | NACK event pulse |

## Verification
The bench targets the count boundaries. If the full-buffer stall were wrong, receive would overrun the fourth byte. If the counter were not cleared on a soft reset, a later start would run stale lengths. If a zero-count start did not take the access-ready path, the engine would get a stray RECV. Bytes left in the buffer before a start must never reach the bus. A design that failed to flush would send them ahead of the real data. In the NACK paths the stop bit must clear and no further command may go out, or the engine would be driven after a refusal. In repeat mode a decrementing or stalled counter would show up as a changed live count or a missing refill.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int C_GO   = 0;
  localparam int C_HALT = 1;
  localparam int C_RPT  = 2;
  localparam int C_TX   = 9;
  localparam int C_MST  = 10;
  localparam int C_EN   = 15;
  localparam logic [15:0] CTL_KEEP = 16'hCF87;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP, S_HELD
  } st_e;

  typedef enum logic [2:0] {
    A_WAIT, A_SEND, A_RECV, A_STOP, A_ARDY
  } act_e;

endpackage

// File: rtl/xfer_buf.sv
module xfer_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] fill;
  logic          do_wr, do_rd;

  assign full    = (fill == FW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/xfer_cnt.sv
module xfer_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] value,
  output logic          zero
);
  assign zero = (value == '0);

  always_ff @(posedge clk) begin
    if (rst)                value <= '0;
    else if (load)          value <= load_val;
    else if (dec && !zero)  value <= value - 1'b1;
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int CW      = 16,
  parameter int DW      = 8,
  parameter int DEPTH   = 4,
  parameter bit OLD_REV = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_q,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt_live,
  input  logic [9:0]    sa,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_byte,
  input  logic          rx_re,
  output logic [DW-1:0] rx_byte,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [9:0]    eng_addr,
  output logic          eng_rd,
  output logic [DW-1:0] eng_wbyte,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rbyte,
  output logic          bus_busy,
  output logic          xrdy,
  output logic          rrdy,
  output logic          ardy_set,
  output logic          nack_set
);
  st_e           state;
  act_e          run_act;
  logic [CW-1:0] cnt_prog;
  logic          soft_rst, start_req, xrdy_run;
  logic          cnt_zero, cnt_load, cnt_dec, cnt_rst;
  logic          buf_full, buf_empty, buf_flush, buf_wr, buf_rd;
  logic [DW-1:0] buf_wdata, buf_head;
  logic          rpt, is_tx, halt;

  assign rpt   = ctl_q[C_RPT];
  assign is_tx = ctl_q[C_TX];
  assign halt  = ctl_q[C_HALT];

  assign soft_rst  = OLD_REV && ctl_we && !ctl_wdata[C_EN];
  assign start_req = ctl_we && ctl_wdata[C_EN] && ctl_wdata[C_MST] && ctl_wdata[C_GO]
                     && (state == S_IDLE || state == S_RUN || state == S_HELD);

  // decision taken in the RUN state
  always_comb begin
    run_act  = A_WAIT;
    xrdy_run = 1'b0;
    if (rpt) begin
      xrdy_run = is_tx && !halt;
      if (halt)          run_act = A_STOP;
      else if (is_tx)    run_act = buf_empty ? A_WAIT : A_SEND;
      else               run_act = buf_full  ? A_WAIT : A_RECV;
    end else if (!cnt_zero) begin
      xrdy_run = is_tx;
      if (is_tx)         run_act = buf_empty ? A_WAIT : A_SEND;
      else               run_act = buf_full  ? A_WAIT : A_RECV;
    end else begin
      run_act = halt ? A_STOP : A_ARDY;
    end
  end

  assign cnt_rst  = rst || soft_rst;
  assign cnt_load = eng_done && ((state == S_START && eng_ack) || state == S_STOP);
  assign cnt_dec  = eng_done && !rpt && (state == S_SEND || state == S_RECV);

  xfer_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(cnt_rst), .load(cnt_load), .load_val(cnt_prog),
    .dec(cnt_dec), .value(cnt_live), .zero(cnt_zero)
  );

  assign buf_flush = start_req || (state == S_STOP && eng_done && is_tx);
  assign buf_wr    = (state == S_RECV && eng_done) || (tx_we && is_tx && state != S_RECV);
  assign buf_wdata = (state == S_RECV) ? eng_rbyte : tx_byte;
  assign buf_rd    = (state == S_RUN && !start_req && run_act == A_SEND) || (rx_re && !is_tx);

  xfer_buf #(.DEPTH(DEPTH), .W(DW)) u_buf (
    .clk(clk), .rst(cnt_rst), .flush(buf_flush), .wr_en(buf_wr), .wr_data(buf_wdata),
    .rd_en(buf_rd), .rd_data(buf_head), .full(buf_full), .empty(buf_empty)
  );

  assign rx_byte  = buf_head;
  assign bus_busy = (state != S_IDLE);
  assign rrdy     = !is_tx && !buf_empty;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= S_IDLE;
      ctl_q     <= '0;
      cnt_prog  <= '0;
      eng_req   <= 1'b0;
      eng_op    <= OP_START;
      eng_addr  <= '0;
      eng_rd    <= 1'b0;
      eng_wbyte <= '0;
      xrdy      <= 1'b0;
      ardy_set  <= 1'b0;
      nack_set  <= 1'b0;
    end else begin
      ardy_set <= 1'b0;
      nack_set <= 1'b0;
      if (cnt_we) cnt_prog <= cnt_wdata;
      if (ctl_we) ctl_q <= ctl_wdata & CTL_KEEP & ~16'h0001;

      if (start_req) begin
        eng_req  <= 1'b1;
        eng_op   <= OP_START;
        eng_addr <= sa;
        eng_rd   <= !ctl_wdata[C_TX];
        xrdy     <= 1'b0;
        state    <= S_START;
      end else begin
        case (state)
          S_START: if (eng_done) begin
            eng_req <= 1'b0;
            if (eng_ack) state <= S_RUN;
            else begin
              nack_set      <= 1'b1;
              ctl_q[C_HALT] <= 1'b0;
              state         <= S_IDLE;
            end
          end
          S_RUN: begin
            xrdy <= xrdy_run;
            case (run_act)
              A_SEND: begin
                eng_req   <= 1'b1;
                eng_op    <= OP_SEND;
                eng_wbyte <= buf_head;
                state     <= S_SEND;
              end
              A_RECV: begin
                eng_req <= 1'b1;
                eng_op  <= OP_RECV;
                state   <= S_RECV;
              end
              A_STOP: begin
                eng_req       <= 1'b1;
                eng_op        <= OP_STOP;
                ctl_q[C_HALT] <= 1'b0;
                state         <= S_STOP;
              end
              A_ARDY: begin
                ardy_set     <= 1'b1;
                ctl_q[C_MST] <= 1'b0;
                state        <= S_HELD;
              end
              default: ;
            endcase
          end
          S_SEND: if (eng_done) begin
            eng_req <= 1'b0;
            if (eng_ack) state <= S_RUN;
            else begin
              nack_set      <= 1'b1;
              ctl_q[C_HALT] <= 1'b0;
              xrdy          <= 1'b0;
              state         <= S_HELD;
            end
          end
          S_RECV: if (eng_done) begin
            eng_req <= 1'b0;
            state   <= S_RUN;
          end
          S_STOP: if (eng_done) begin
            eng_req <= 1'b0;
            xrdy    <= 1'b0;
            state   <= S_IDLE;
          end
          S_HELD: begin
            xrdy <= 1'b0;
            if (ctl_we && ctl_wdata[C_EN] && ctl_wdata[C_HALT]) begin
              eng_req       <= 1'b1;
              eng_op        <= OP_STOP;
              ctl_q[C_HALT] <= 1'b0;
              state         <= S_STOP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_we,
  input logic [15:0]   ctl_q,
  input logic [CW-1:0] cnt_live,
  input logic          eng_req,
  input logic [1:0]    eng_op,
  input logic          eng_done,
  input logic          bus_busy,
  input logic          ardy_set,
  input logic          nack_set
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done && !ctl_we) |=> (eng_req && $stable(eng_op))); // R12
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !bus_busy |-> !eng_req); // R3
  AST_NACK_HALT: assert property (@(posedge clk) disable iff (rst)
    nack_set |-> !ctl_q[1]); // R11
  AST_ARDY_STATE: assert property (@(posedge clk) disable iff (rst)
    ardy_set |-> (!ctl_q[10] && cnt_live == '0 && bus_busy)); // R9
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ardy_set && nack_set)); // R9
endmodule

bind xfer_seq xfer_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_q(ctl_q), .cnt_live(cnt_live),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done), .bus_busy(bus_busy),
  .ardy_set(ardy_set), .nack_set(nack_set)
);

// File: tb/xfer_seq_test.sv
`timescale 1ns/1ps
module xfer_seq_test;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_we = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic [15:0]   ctl_q;
  logic          cnt_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] cnt_live;
  logic [9:0]    sa = 10'h1A5;
  logic          tx_we = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          rx_re = 1'b0;
  logic [DW-1:0] rx_byte;
  logic          eng_req;
  logic [1:0]    eng_op;
  logic [9:0]    eng_addr;
  logic          eng_rd;
  logic [DW-1:0] eng_wbyte;
  logic          eng_done = 1'b0;
  logic          eng_ack = 1'b0;
  logic [DW-1:0] eng_rbyte = '0;
  logic          bus_busy, xrdy, rrdy, ardy_set, nack_set;

  always #10 clk = ~clk;

  xfer_seq uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_live(cnt_live), .sa(sa),
    .tx_we(tx_we), .tx_byte(tx_byte), .rx_re(rx_re), .rx_byte(rx_byte),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_rd(eng_rd),
    .eng_wbyte(eng_wbyte), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rbyte(eng_rbyte),
    .bus_busy(bus_busy), .xrdy(xrdy), .rrdy(rrdy), .ardy_set(ardy_set), .nack_set(nack_set)
  );

  // engine model and log
  int        phase = 0;
  int        nlog = 0;
  int        nsend = 0;
  int        nack_at = 0;
  bit        nack_start = 1'b0;
  logic [7:0] rnext = 8'hA0;
  logic [1:0] log_op [64];
  logic [7:0] log_b  [64];
  logic [9:0] log_a  [64];
  logic       log_rd [64];
  int        ardy_n = 0;
  int        nack_n = 0;

  always @(posedge clk) begin
    if (ardy_set) ardy_n++;
    if (nack_set) nack_n++;
    case (phase)
      0: if (eng_req && !rst) begin
        if (nlog < 64) begin
          log_op[nlog] = eng_op;
          log_b[nlog]  = eng_wbyte;
          log_a[nlog]  = eng_addr;
          log_rd[nlog] = eng_rd;
        end
        nlog++;
        phase = 1;
      end
      1: begin
        eng_done <= 1'b1;
        if (eng_op == 2'd0) eng_ack <= !nack_start;
        else if (eng_op == 2'd1) begin
          nsend++;
          eng_ack <= (nsend != nack_at);
        end else eng_ack <= 1'b1;
        if (eng_op == 2'd2) begin
          eng_rbyte <= rnext;
          rnext = rnext + 8'd1;
        end
        phase = 2;
      end
      default: begin
        eng_done <= 1'b0;
        phase = 0;
      end
    endcase
  end

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CW-1:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_we = 1'b1; tx_byte = b;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp);
    @(negedge clk);
    chk(rx_byte == exp, "R7 rx order", rx_byte, exp);
    rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic t_reset();
    chk(ctl_q == 16'h0, "R1 ctl", ctl_q, 0);
    chk(cnt_live == '0, "R1 count", cnt_live, 0);
    chk(!bus_busy && !eng_req, "R1 idle", {bus_busy, eng_req}, 0);
    chk(!xrdy && !rrdy, "R1 flags", {xrdy, rrdy}, 0);
  endtask

  task automatic t_ignored_start();
    nlog = 0;
    wr_ctl(16'h8001);
    tick(20);
    chk(nlog == 0, "R2 start without master ignored", nlog, 0);
    chk(ctl_q == 16'h8000, "R2 mask and start clear", ctl_q, 16'h8000);
    chk(!bus_busy, "R2 still idle", bus_busy, 0);
  endtask

  task automatic t_tx_counted();
    int a0;
    a0 = ardy_n;
    wr_cnt(3);
    wr_ctl(16'hFE86);
    chk(ctl_q == 16'hCE86, "R2 keep mask", ctl_q, 16'hCE86);
    push(8'h77);
    nlog = 0; nsend = 0;
    wr_ctl(16'h8603);
    tick(20);
    chk(nlog == 1 && log_op[0] == 2'd0, "R2 START issued", nlog, 1);
    chk(log_a[0] == 10'h1A5 && log_rd[0] == 1'b0, "R2 addr/dir", {log_rd[0], log_a[0]}, 10'h1A5);
    chk(ctl_q[0] == 1'b0, "R2 start self-clear", ctl_q, 0);
    chk(cnt_live == 3, "R4 count loaded", cnt_live, 3);
    chk(xrdy == 1'b1, "R6 xrdy while waiting", xrdy, 1);
    push(8'h11); push(8'h22); push(8'h33);
    tick(60);
    chk(nlog == 5, "R12 one log per command", nlog, 5);
    chk(log_op[1] == 2'd1 && log_b[1] == 8'h11, "R4 stale byte flushed", log_b[1], 8'h11);
    chk(log_b[2] == 8'h22 && log_b[3] == 8'h33, "R5 send order", {log_b[2], log_b[3]}, 16'h2233);
    chk(log_op[4] == 2'd3, "R8 STOP at zero", log_op[4], 3);
    chk(ctl_q[1] == 1'b0, "R8 stop cleared", ctl_q, 0);
    chk(cnt_live == 3, "R8 reload", cnt_live, 3);
    chk(!bus_busy && !eng_req, "R8 idle after stop", bus_busy, 0);
    chk(!xrdy, "R6 xrdy low after end", xrdy, 0);
    chk(ardy_n == a0, "R8 no ardy with stop", ardy_n - a0, 0);
  endtask

  task automatic t_rx_counted_stop();
    nlog = 0; rnext = 8'hA0;
    wr_cnt(6);
    wr_ctl(16'h8403);
    tick(60);
    chk(nlog == 5, "R7 stall at full buffer", nlog, 5);
    chk(log_rd[0] == 1'b1, "R2 read start", log_rd[0], 1);
    chk(rrdy == 1'b1, "R7 rrdy", rrdy, 1);
    chk(cnt_live == 2, "R7 count decremented", cnt_live, 2);
    pop_chk(8'hA0); pop_chk(8'hA1); pop_chk(8'hA2); pop_chk(8'hA3);
    tick(60);
    chk(nlog == 8 && log_op[7] == 2'd3, "R8 rx stop", nlog, 8);
    chk(log_op[5] == 2'd2 && log_op[6] == 2'd2, "R7 remaining receives", {log_op[5], log_op[6]}, 4'hA);
    chk(!bus_busy && cnt_live == 6, "R8 reload rx", cnt_live, 6);
    pop_chk(8'hA4); pop_chk(8'hA5);
    chk(!rrdy, "R7 rrdy empty", rrdy, 0);
  endtask

  task automatic t_rx_ardy();
    int a0;
    a0 = ardy_n;
    nlog = 0; rnext = 8'hA0;
    wr_cnt(1);
    wr_ctl(16'h8401);
    tick(40);
    chk(nlog == 2, "R9 one receive", nlog, 2);
    chk(ardy_n == a0 + 1, "R9 ardy pulse", ardy_n - a0, 1);
    chk(ctl_q[10] == 1'b0, "R9 master cleared", ctl_q, 0);
    chk(bus_busy && cnt_live == 0, "R9 held", {bus_busy, cnt_live}, 17'h10000);
    tick(20);
    chk(nlog == 2 && ardy_n == a0 + 1, "R9 quiet while held", nlog, 2);
    pop_chk(8'hA0);
    wr_ctl(16'h8002);
    tick(20);
    chk(nlog == 3 && log_op[2] == 2'd3, "R9 stop from held", nlog, 3);
    chk(!bus_busy && cnt_live == 1, "R9 released", cnt_live, 1);
  endtask

  task automatic t_start_nack();
    int n0;
    n0 = nack_n;
    nlog = 0; nack_start = 1'b1;
    wr_cnt(2);
    wr_ctl(16'h8603);
    tick(30);
    chk(nack_n == n0 + 1, "R3 nack pulse", nack_n - n0, 1);
    chk(ctl_q[1] == 1'b0, "R3 stop cleared", ctl_q, 0);
    chk(!bus_busy && nlog == 1, "R3 idle no command", nlog, 1);
    nack_start = 1'b0;
  endtask

  task automatic t_send_nack();
    int n0;
    n0 = nack_n;
    nlog = 0; nsend = 0; nack_at = 1;
    wr_cnt(3);
    wr_ctl(16'h8603);
    tick(10);
    push(8'h44); push(8'h55);
    tick(40);
    chk(nlog == 2 && log_b[1] == 8'h44, "R11 single send", nlog, 2);
    chk(nack_n == n0 + 1 && ctl_q[1] == 1'b0, "R11 nack and stop clear", ctl_q, 0);
    chk(bus_busy && !xrdy, "R11 held, xrdy low", {bus_busy, xrdy}, 2);
    chk(cnt_live == 2, "R5 decrement on send", cnt_live, 2);
    nack_at = 0;
    wr_ctl(16'h8002);
    tick(20);
    chk(!bus_busy && log_op[2] == 2'd3, "R11 stop releases", bus_busy, 0);
  endtask

  task automatic t_rpt_rx();
    nlog = 0; rnext = 8'hA0;
    wr_cnt(0);
    wr_ctl(16'h8405);
    tick(60);
    chk(nlog == 5, "R10 fill to depth", nlog, 5);
    chk(cnt_live == 0 && bus_busy && rrdy, "R10 count ignored", cnt_live, 0);
    pop_chk(8'hA0);
    tick(30);
    chk(nlog == 6 && log_op[5] == 2'd2, "R10 refill", nlog, 6);
    wr_ctl(16'h8406);
    tick(20);
    chk(nlog == 7 && log_op[6] == 2'd3 && !bus_busy, "R10 stop at once", nlog, 7);
  endtask

  task automatic t_rpt_tx();
    nlog = 0; nsend = 0;
    wr_cnt(5);
    wr_ctl(16'h8605);
    tick(20);
    push(8'h61); push(8'h62);
    tick(40);
    chk(nlog == 3 && log_b[1] == 8'h61 && log_b[2] == 8'h62, "R10 drain", nlog, 3);
    chk(cnt_live == 5, "R10 count unchanged", cnt_live, 5);
    chk(xrdy && bus_busy, "R6 xrdy repeat", xrdy, 1);
    wr_ctl(16'h8606);
    tick(20);
    chk(!bus_busy && log_op[3] == 2'd3, "R10 tx stop", bus_busy, 0);
  endtask

  task automatic t_soft_reset();
    int a0;
    nlog = 0;
    wr_cnt(4);
    wr_ctl(16'h8401);
    tick(60);
    chk(bus_busy && rrdy, "R13 setup held", bus_busy, 1);
    wr_ctl(16'h0000);
    tick(2);
    chk(!bus_busy && ctl_q == 0 && cnt_live == 0, "R13 state cleared", {bus_busy, ctl_q}, 0);
    chk(!rrdy, "R13 buffer cleared", rrdy, 0);
    a0 = ardy_n; nlog = 0;
    wr_ctl(16'h8401);
    tick(30);
    chk(nlog == 1 && ardy_n == a0 + 1, "R13 programmed count cleared", nlog, 1);
    wr_ctl(16'h0000);
    tick(2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_ignored_start();
    t_tx_counted();
    t_rx_counted_stop();
    t_rx_ardy();
    t_start_nack();
    t_send_nack();
    t_rpt_rx();
    t_rpt_tx();
    t_soft_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule